// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a general-purpose I/O controller split into a parameterised number of banks. Each bank has up to 32 lines. For every line a bank holds an output latch, a direction bit and an open-drain enable. Each line also has its own interrupt detector, which can watch for a level, a single edge or both edges. Pad inputs are synchronised before detection. The pad side of each line is a separate input, output and output-enable, which a pad cell outside the block combines.

Software reaches every register through a word-addressed bus with a write strobe, a read strobe and an address. The address carries the bank number in its upper bits and the register index in its lower three bits. The masked pending status bits of all banks are ORed into a single interrupt output. Software services a line by clearing its status bit: writing a one to that bit clears it.

Top module: `mbgpio_ctrl`

## Requirements
- R1: A word address holds the bank number in its upper bits and the register index in its lower three bits. The indices are: 0 open-drain enable, 1 data, 2 direction, 3 edge select, 4 both-edge select, 5 mask, 6 level select, 7 status. Read data appears on `rd_data` on the clock edge that samples `rd_en`.
- R2: After reset every register is zero. Every implemented line is then an output driving low with `pad_oe` high, all interrupts are masked, and `irq` is low.
- R3: A direction bit of 0 makes the line an output (`pad_oe` high, `pad_out` equal to the data bit). A direction bit of 1 makes it an input (`pad_oe` low).
- R4: Reading the data register returns the latch value for output lines. For input lines it returns the pad level after a two-flop synchroniser.
- R5: When open-drain is enabled on an output line, `pad_out` is 0. `pad_oe` is high only while the data bit is 0, so a data bit of 1 releases the line.
- R6: With level select 0 and both-edge select 0, an edge-select bit of 1 sets the status bit on a rising pad edge and 0 sets it on a falling edge. The status bit is set on the third rising clock edge after the pad changes.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a clear and a new event fall in the same cycle, the clear wins.
- R8: With level select 0 and both-edge select 1, both rising and falling pad edges set the status bit.
- R9: Bank widths come from a parameter. Bits at or above a bank's width read as zero, ignore writes, keep `pad_out` and `pad_oe` low and never set status.
- R10: With level select 1, the status bit follows an active-high condition when edge select is 1 and an active-low condition when it is 0. While the condition persists, the bit sets again in the cycle after it is cleared.
- R11: Addresses whose bank field is not below the bank count read as zero, and writes to them change no register.
- R12: `irq` is high exactly while some status bit and its mask bit are both 1, in any bank. A masked status bit is still visible in the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address: bank number in the upper bits, register index in the low 3 bits |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pad_in | input | NB*32 | Pad input levels, 32 per bank |
| pad_out | output | NB*32 | Pad output levels |
| pad_oe | output | NB*32 | Pad output enables |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that every write to a status register comes from a completed bus write of one cycle. They also assume that pad inputs change at most once per clock period, so the synchroniser and the one-cycle edge history see each change. The stimulus changes bus signals and pads only on falling clock edges, holds every pad level for at least three cycles before it judges the interrupt, and clears status before it unmasks a line, so that changes of configuration do not leave stale events behind.

// File: rtl/mbgpio_ctrl.sv
module mbgpio_ctrl #(
  parameter int NB = 2,
  parameter logic [NB*8-1:0] BANK_WIDTHS = {8'd20, 8'd32},
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  input  logic [NB*32-1:0]  pad_in,
  output logic [NB*32-1:0]  pad_out,
  output logic [NB*32-1:0]  pad_oe,
  output logic              irq
);
  localparam int BAW = AW - 3;

  logic [NB*32-1:0] impl, sync1, sync2, prev, stat_q, mask_q;
  logic [BAW-1:0]   bsel;
  logic [2:0]       rsel;
  logic [31:0]      bank_rd [NB];
  logic [31:0]      rd_mux;

  assign bsel = addr[AW-1:3];
  assign rsel = addr[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in & impl;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int W = int'(BANK_WIDTHS[b*8 +: 8]);
    logic [31:0] m, wd, s2, pv, rise, fall, ev, clr;
    logic [31:0] oden, data, dir, ec, ei, mask, lvl, stat;
    logic        sel;

    assign m  = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
    assign impl[b*32 +: 32] = m;
    assign sel  = wr_en && (int'(bsel) == b);
    assign wd   = wr_data & m;
    assign s2   = sync2[b*32 +: 32];
    assign pv   = prev[b*32 +: 32];
    assign rise = s2 & ~pv;
    assign fall = ~s2 & pv;
    assign ev   = m & ((lvl & ~(s2 ^ ec)) |
                       (~lvl & ei & (rise | fall)) |
                       (~lvl & ~ei & ((ec & rise) | (~ec & fall))));
    assign clr  = (sel && rsel == 3'd7) ? wd : 32'h0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        oden <= '0; data <= '0; dir <= '0; ec <= '0;
        ei <= '0; mask <= '0; lvl <= '0;
      end else if (sel) begin
        case (rsel)
          3'd0: oden <= wd;
          3'd1: data <= wd;
          3'd2: dir  <= wd;
          3'd3: ec   <= wd;
          3'd4: ei   <= wd;
          3'd5: mask <= wd;
          3'd6: lvl  <= wd;
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat | ev) & ~clr & m;
    end

    assign stat_q[b*32 +: 32]  = stat;
    assign mask_q[b*32 +: 32]  = mask;
    assign pad_out[b*32 +: 32] = data & ~oden & m;
    assign pad_oe[b*32 +: 32]  = ~dir & ~(oden & data) & m;

    always_comb begin
      case (rsel)
        3'd0: bank_rd[b] = oden;
        3'd1: bank_rd[b] = (data & ~dir) | (s2 & dir);
        3'd2: bank_rd[b] = dir;
        3'd3: bank_rd[b] = ec;
        3'd4: bank_rd[b] = ei;
        3'd5: bank_rd[b] = mask;
        3'd6: bank_rd[b] = lvl;
        default: bank_rd[b] = stat;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NB; b++)
      if (int'(bsel) == b) rd_mux = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  assign irq = |(stat_q & mask_q);
endmodule

module mbgpio_chk #(
  parameter int NB = 2,
  parameter int AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic             rd_en,
  input logic [31:0]      rd_data,
  input logic [NB*32-1:0] pad_out,
  input logic [NB*32-1:0] pad_oe,
  input logic [NB*32-1:0] impl,
  input logic [NB*32-1:0] stat_q
);
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(addr) >= NB*8) |=> (rd_data == 32'h0));  // R11
  AST_UNIMPL_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out | pad_oe | stat_q) & ~impl) == '0);  // R9
  AST_DIR_INPUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 2 && wr_data == 32'hFFFF_FFFF) |=> (pad_oe[31:0] == 32'h0));  // R3
  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == 7) |=> ((stat_q[31:0] & $past(wr_data)) == 32'h0));  // R7
endmodule

bind mbgpio_ctrl mbgpio_chk #(.NB(NB), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .pad_out(pad_out), .pad_oe(pad_oe),
  .impl(impl), .stat_q(stat_q)
);

// File: tb/sim_mbgpio_ctrl.sv
module sim_mbgpio_ctrl;
  localparam int NB = 2;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NB*32-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;
  int checks = 0, fails = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  mbgpio_ctrl #(.NB(NB), .BANK_WIDTHS({8'd20, 8'd32}), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R2 pad_oe", pad_oe, {12'h0, 20'hFFFFF, 32'hFFFF_FFFF});
    chk("R2 pad_out", pad_out, 64'h0);
    chk("R2 irq", {63'h0, irq}, 64'h0);
    rd(5, v); chk("R2 mask", {32'h0, v}, 64'h0);
    rd(2, v); chk("R1 R2 dir", {32'h0, v}, 64'h0);
  endtask

  task automatic t_output;
    wr(1, 32'hA5A5_0F0F);
    chk("R3 pad_out", {32'h0, pad_out[31:0]}, {32'h0, 32'hA5A5_0F0F});
    wr(2, 32'hFFFF_FFFF);
    chk("R3 all input", {32'h0, pad_oe[31:0]}, 64'h0);
    wr(2, 32'hFFFF_0000);
    chk("R3 pad_oe", {32'h0, pad_oe[31:0]}, {32'h0, 32'h0000_FFFF});
    rd(2, v); chk("R1 dir readback", {32'h0, v}, {32'h0, 32'hFFFF_0000});
  endtask

  task automatic t_input;
    pad_in[31:16] = 16'hBEEF;
    cyc(3);
    rd(1, v); chk("R4 data read", {32'h0, v}, {32'h0, 32'hBEEF_0F0F});
  endtask

  task automatic t_opendrain;
    wr(1, 32'hA5A5_0F05);
    wr(0, 32'h0000_000F);
    chk("R5 pad_out low", {60'h0, pad_out[3:0]}, 64'h0);
    chk("R5 pad_oe", {60'h0, pad_oe[3:0]}, {60'h0, 4'b1010});
    wr(0, 32'h0);
    chk("R5 released", {60'h0, pad_out[3:0]}, {60'h0, 4'h5});
  endtask

  task automatic t_width;
    wr(9, 32'hFFFF_FFFF);
    rd(9, v); chk("R9 data width", {32'h0, v}, {32'h0, 32'h000F_FFFF});
    chk("R9 pad_out", pad_out[63:32], {32'h0, 32'h000F_FFFF});
    wr(9, 32'h0);
  endtask

  task automatic t_unmapped;
    rd(4, v); chk("R11 before", {32'h0, v}, 64'h0);
    wr(20, 32'hFFFF_FFFF);
    rd(20, v); chk("R11 read zero", {32'h0, v}, 64'h0);
    rd(4, v); chk("R11 no alias", {32'h0, v}, 64'h0);
    rd(12, v); chk("R11 bank1 untouched", {32'h0, v}, 64'h0);
  endtask

  task automatic t_rise;
    wr(3, 32'h8); wr(7, 32'hFFFF_FFFF); wr(5, 32'h8);
    chk("R12 idle", {63'h0, irq}, 64'h0);
    pad_in[3] = 1'b1;
    cyc(2); chk("R6 latency", {63'h0, irq}, 64'h0);
    cyc(1); chk("R6 rising", {63'h0, irq}, 64'h1);
    rd(7, v); chk("R6 status", {32'h0, v}, {32'h0, 32'h8});
    wr(7, 32'h0);
    rd(7, v); chk("R7 zero write", {32'h0, v}, {32'h0, 32'h8});
    wr(7, 32'h8);
    chk("R7 clear", {63'h0, irq}, 64'h0);
    pad_in[3] = 1'b0;
    cyc(4); chk("R6 no fall in rise mode", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_fall;
    wr(3, 32'h0);
    pad_in[3] = 1'b1;
    cyc(4); chk("R6 no rise in fall mode", {63'h0, irq}, 64'h0);
    pad_in[3] = 1'b0;
    cyc(3); chk("R6 falling", {63'h0, irq}, 64'h1);
    wr(7, 32'h8);
  endtask

  task automatic t_both;
    wr(4, 32'h8);
    pad_in[3] = 1'b1;
    cyc(3); chk("R8 rise", {63'h0, irq}, 64'h1);
    wr(7, 32'h8);
    pad_in[3] = 1'b0;
    cyc(3); chk("R8 fall", {63'h0, irq}, 64'h1);
    wr(7, 32'h8);
    wr(4, 32'h0);
  endtask

  task automatic t_level;
    wr(3, 32'h8); wr(6, 32'h8); wr(7, 32'h8);
    chk("R10 inactive", {63'h0, irq}, 64'h0);
    pad_in[3] = 1'b1;
    cyc(3); chk("R10 high", {63'h0, irq}, 64'h1);
    wr(7, 32'h8);
    chk("R10 cleared", {63'h0, irq}, 64'h0);
    cyc(1); chk("R10 reasserts", {63'h0, irq}, 64'h1);
    pad_in[3] = 1'b0;
    cyc(3); wr(7, 32'h8); cyc(2);
    chk("R10 released", {63'h0, irq}, 64'h0);
    wr(3, 32'h0);
    cyc(1); wr(7, 32'h8); cyc(1);
    chk("R10 active low", {63'h0, irq}, 64'h1);
    pad_in[3] = 1'b1;
    cyc(3); wr(7, 32'h8); cyc(2);
    chk("R10 low released", {63'h0, irq}, 64'h0);
    wr(6, 32'h0); wr(7, 32'hFFFF_FFFF); wr(5, 32'h0);
  endtask

  task automatic t_bank1;
    wr(11, 32'h20); wr(15, 32'hFFFF_FFFF); wr(13, 32'h20);
    pad_in[37] = 1'b1;
    cyc(3); chk("R12 bank1 irq", {63'h0, irq}, 64'h1);
    wr(13, 32'h0);
    chk("R12 masked", {63'h0, irq}, 64'h0);
    rd(15, v); chk("R12 status visible", {32'h0, v}, {32'h0, 32'h20});
    wr(15, 32'hFFFF_FFFF);
  endtask

  task automatic t_unimpl;
    wr(12, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF); wr(13, 32'hFFFF_FFFF);
    pad_in[57] = 1'b1;
    cyc(4); chk("R9 no irq", {63'h0, irq}, 64'h0);
    rd(15, v); chk("R9 no status", {32'h0, v}, 64'h0);
    rd(12, v); chk("R9 ei width", {32'h0, v}, {32'h0, 32'h000F_FFFF});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset; t_output; t_input; t_opendrain; t_width; t_unmapped;
    t_rise; t_fall; t_both; t_level; t_bank1; t_unimpl;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule